// File: doc/BRIEF.md
# Bias-Adjusted Top-K Expert Router

This block picks K experts for every token of a mixture-of-experts layer. For each token it receives one unsigned fixed-point affinity score per routed expert, already computed upstream. A signed bias register per expert is added to that expert's score, and only this sum decides which experts win. The gate weights sent out with the winners come from the raw scores alone, scaled so that they share one unit among the chosen experts.

Experts are grouped into nodes of equal size. Each node is ranked by the sum of its best K/M biased scores, and only experts on the M best nodes may be chosen. Across a training step the block counts how often each expert is picked. When a step-end pulse arrives, it moves each bias one fixed step against that expert's load, so that busy experts lose ground and idle ones gain it. Gate normalisation runs on a single shared sequential divider. A token therefore occupies the block for a fixed number of cycles, and the result appears with a one-cycle valid strobe. The configuration needs K to be at most M times the experts per node, and K to be at least 2.

Top module: `topk_router`

## Requirements
- R1: Each expert's key is its score plus its own bias, taken as signed. Among eligible experts the K largest keys are chosen. On equal keys the lower expert index wins. Slot r of `out_idx` (bits r*IW upward) holds the expert ranked r, with slot 0 the largest key.
- R2: A node's merit is the sum of the K/M largest keys among its experts, where expert e belongs to node e/(N_EXP/N_NODE). On equal keys within a node the lower index counts first. The M nodes of largest merit are eligible, with the lower node index winning on equal merit. No expert outside them is chosen.
- R3: Slot r of `out_gate` (bits r*(FRAC+1) upward) equals floor(raw_score_r * 2^FRAC / S), where S is the sum of the raw scores of the K chosen experts. Biases play no part in this value. When S is zero every gate is zero.
- R4: `out_valid` pulses for exactly one cycle, K*(FRAC+1) clock edges after the edge that accepts a token. `out_idx` and `out_gate` then hold their values until the next pulse.
- R5: A token is accepted only while `busy` is low. A token offered while `busy` is high creates no result and is not counted as load. `busy` is low again in the cycle where `out_valid` is high.
- R6: Each expert's load is the number of accepted tokens that chose it since the last step end.
- R7: On a step-end pulse, an expert whose load times N_EXP exceeds the token count times K has its bias lowered by GAMMA. An expert below that level has its bias raised by GAMMA. An expert exactly at that level keeps its bias. The loads then restart, and a token accepted in the same cycle as the pulse counts toward the new step.
- R8: Bias updates saturate at the signed limits of BW bits.
- R9: After reset, all biases, `busy`, `out_valid`, `out_idx` and `out_gate` are zero.
- R10: Biases change only on a step-end pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A token's scores are present |
| in_score | input | N_EXP*SW | Unsigned affinity per expert; expert e at bits e*SW upward |
| step_end | input | 1 | End-of-step pulse that triggers the bias update |
| busy | output | 1 | A token is being normalised; new tokens are not taken |
| out_valid | output | 1 | One-cycle strobe: result ready |
| out_idx | output | K*IW | Chosen expert indices, ordered by rank |
| out_gate | output | K*(FRAC+1) | Gate weights with FRAC fraction bits |
| bias_q | output | N_EXP*BW | Current signed bias per expert |

## Verification
The bench builds the router with 12 experts on 4 nodes of three, K=4, M=2, 8-bit scores and biases, 8 fraction bits and a bias step of 40. With three experts per node and a top-two node sum, the choice inside each node matters. Scores drawn from a small range give frequent ties between experts and between nodes. A step of 40 drives biases into both saturation limits within four steps. The 36-cycle token latency keeps many tokens, busy-window collisions and step ends within a short run.

// File: rtl/topk_router.sv
`timescale 1ns/1ps
module topk_router #(
  parameter int N_EXP  = 32,
  parameter int N_NODE = 8,
  parameter int K      = 8,
  parameter int M      = 4,
  parameter int SW     = 16,
  parameter int BW     = 16,
  parameter int FRAC   = 16,
  parameter int GAMMA  = 1,
  parameter int CNTW   = 16,
  localparam int IW    = $clog2(N_EXP),
  localparam int GW    = FRAC + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [N_EXP*SW-1:0]   in_score,
  input  logic                  step_end,
  output logic                  busy,
  output logic                  out_valid,
  output logic [K*IW-1:0]       out_idx,
  output logic [K*GW-1:0]       out_gate,
  output logic [N_EXP*BW-1:0]   bias_q
);
  localparam int EPN   = N_EXP / N_NODE;
  localparam int KPN   = K / M;
  localparam int KW    = (SW > BW ? SW : BW) + 2;
  localparam int NW    = KW + $clog2(KPN + 1);
  localparam int SUMW  = SW + $clog2(K) + 1;
  localparam int LW    = CNTW + $clog2(N_EXP) + $clog2(K) + 1;
  localparam int SLW   = $clog2(K);
  localparam int STW   = $clog2(GW);
  localparam int BMAXI = 2 ** (BW - 1) - 1;

  logic signed [BW-1:0] bias_r [N_EXP];
  logic [CNTW-1:0]      cnt_r  [N_EXP];
  logic [CNTW-1:0]      tok_r;
  logic signed [KW-1:0] key    [N_EXP];
  logic signed [NW-1:0] nsum   [N_NODE];
  logic [N_NODE-1:0]    node_ok, node_hit;
  logic [N_EXP-1:0]     pick, over, under;
  logic [IW-1:0]        pidx   [K];
  logic [SW-1:0]        psc    [K];
  logic [SUMW-1:0]      psum, sum_r;
  logic [IW-1:0]        idx_r  [K];
  logic [SW-1:0]        sc_r   [K];
  logic [GW-1:0]        gw_r   [K];
  logic [SLW-1:0]       slot;
  logic [STW-1:0]       step;
  logic [SUMW:0]        rem, base;
  logic [GW-1:0]        q_r, newq;
  logic                 qbit, accept;
  logic [GW+SLW+1:0]    gsum;

  function automatic logic ahead(input logic signed [NW-1:0] x, input logic signed [NW-1:0] y,
                                 input int i, input int j);
    return (x > y) || (x == y && i < j);
  endfunction

  function automatic logic signed [BW-1:0] nudge(input logic signed [BW-1:0] b, input logic up);
    logic signed [BW:0] t;
    t = up ? (BW+1)'(b) + (BW+1)'(GAMMA) : (BW+1)'(b) - (BW+1)'(GAMMA);
    if (t > (BW+1)'(BMAXI)) return BW'(BMAXI);
    if (t < (BW+1)'(-BMAXI - 1)) return BW'(-BMAXI - 1);
    return BW'(t);
  endfunction

  assign accept = in_valid && !busy;

  always_comb begin
    int rk;
    for (int e = 0; e < N_EXP; e++)
      key[e] = KW'(signed'({1'b0, in_score[e*SW +: SW]})) + KW'(bias_r[e]);
    for (int n = 0; n < N_NODE; n++) begin
      nsum[n] = '0;
      for (int a = 0; a < EPN; a++) begin
        rk = 0;
        for (int b = 0; b < EPN; b++)
          if (ahead(NW'(key[n*EPN+b]), NW'(key[n*EPN+a]), b, a)) rk++;
        if (rk < KPN) nsum[n] = nsum[n] + NW'(key[n*EPN+a]);
      end
    end
    for (int n = 0; n < N_NODE; n++) begin
      rk = 0;
      for (int m = 0; m < N_NODE; m++)
        if (ahead(nsum[m], nsum[n], m, n)) rk++;
      node_ok[n] = (rk < M);
    end
    pick = '0;
    psum = '0;
    for (int k = 0; k < K; k++) begin
      pidx[k] = '0;
      psc[k]  = '0;
    end
    for (int e = 0; e < N_EXP; e++) begin
      rk = 0;
      for (int f = 0; f < N_EXP; f++)
        if (node_ok[f/EPN] && ahead(NW'(key[f]), NW'(key[e]), f, e)) rk++;
      if (node_ok[e/EPN] && rk < K) begin
        pick[e] = 1'b1;
        pidx[rk[SLW-1:0]] = IW'(e);
        psc[rk[SLW-1:0]]  = in_score[e*SW +: SW];
        psum = psum + SUMW'(in_score[e*SW +: SW]);
      end
    end
  end

  always_comb begin
    for (int e = 0; e < N_EXP; e++) begin
      over[e]  = (LW'(cnt_r[e]) * LW'(N_EXP)) > (LW'(tok_r) * LW'(K));
      under[e] = (LW'(cnt_r[e]) * LW'(N_EXP)) < (LW'(tok_r) * LW'(K));
    end
    for (int n = 0; n < N_NODE; n++) node_hit[n] = |pick[n*EPN +: EPN];
    gsum = '0;
    for (int k = 0; k < K; k++) gsum = gsum + (GW+SLW+2)'(out_gate[k*GW +: GW]);
  end

  assign base = (step == '0) ? (SUMW+1)'(sc_r[slot]) : {rem[SUMW-1:0], 1'b0};
  assign qbit = (sum_r != '0) && (base >= (SUMW+1)'(sum_r));
  assign newq = {q_r[GW-2:0], qbit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; out_valid <= 1'b0; slot <= '0; step <= '0; rem <= '0; q_r <= '0;
      sum_r <= '0; tok_r <= '0; out_idx <= '0; out_gate <= '0;
      for (int e = 0; e < N_EXP; e++) begin bias_r[e] <= '0; cnt_r[e] <= '0; end
      for (int k = 0; k < K; k++) begin idx_r[k] <= '0; sc_r[k] <= '0; gw_r[k] <= '0; end
    end else begin
      out_valid <= 1'b0;
      if (accept) begin
        busy <= 1'b1; slot <= '0; step <= '0; sum_r <= psum;
        for (int k = 0; k < K; k++) begin idx_r[k] <= pidx[k]; sc_r[k] <= psc[k]; end
      end else if (busy) begin
        q_r <= newq;
        rem <= qbit ? base - (SUMW+1)'(sum_r) : base;
        if (step == STW'(FRAC)) begin
          step <= '0;
          gw_r[slot] <= newq;
          if (slot == SLW'(K - 1)) begin
            busy <= 1'b0; out_valid <= 1'b1;
            for (int k = 0; k < K; k++) begin
              out_idx[k*IW +: IW]  <= idx_r[k];
              out_gate[k*GW +: GW] <= (k == K - 1) ? newq : gw_r[k];
            end
          end else slot <= slot + 1'b1;
        end else step <= step + 1'b1;
      end
      if (step_end) begin
        tok_r <= CNTW'(accept);
        for (int e = 0; e < N_EXP; e++) begin
          cnt_r[e] <= CNTW'(accept && pick[e]);
          if (over[e]) bias_r[e] <= nudge(bias_r[e], 1'b0);
          else if (under[e]) bias_r[e] <= nudge(bias_r[e], 1'b1);
        end
      end else if (accept) begin
        tok_r <= tok_r + 1'b1;
        for (int e = 0; e < N_EXP; e++) cnt_r[e] <= cnt_r[e] + CNTW'(pick[e]);
      end
    end
  end

  for (genvar e = 0; e < N_EXP; e++) begin : g_bias
    assign bias_q[e*BW +: BW] = bias_r[e];
    assert_bias_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !step_end |=> $stable(bias_r[e]));
  end

  assert_k_picked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $countones(pick) == K);
  assert_node_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $countones(node_hit) <= M);
  assert_gate_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> gsum <= (GW+SLW+2)'(2 ** FRAC));
  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  assert_idle_at_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !busy);
endmodule

// File: tb/test_topk_router.sv
`timescale 1ns/1ps
module test_topk_router;
  localparam int NE = 12, NN = 4, KK = 4, MM = 2, SW = 8, BW = 8, FR = 8, GAM = 40, CW = 12;
  localparam int IW = $clog2(NE), GW = FR + 1, EPN = NE / NN, KPN = KK / MM, LAT = KK * GW;

  logic clk, rst_n, in_valid, step_end, busy, out_valid;
  logic [NE*SW-1:0] in_score;
  logic [KK*IW-1:0] out_idx;
  logic [KK*GW-1:0] out_gate;
  logic [NE*BW-1:0] bias_q;

  topk_router #(.N_EXP(NE), .N_NODE(NN), .K(KK), .M(MM), .SW(SW), .BW(BW), .FRAC(FR),
                .GAMMA(GAM), .CNTW(CW)) i_topk_router (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_score(in_score), .step_end(step_end),
    .busy(busy), .out_valid(out_valid), .out_idx(out_idx), .out_gate(out_gate), .bias_q(bias_q));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int sm[NE], bm[NE], cm[NE], key[NE], sel[KK];
  int tm;
  bit nok[NN];
  int unsigned seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int unsigned rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed >> 8;
  endfunction

  function automatic void set_pattern(input int mode);
    for (int e = 0; e < NE; e++)
      case (mode)
        0: sm[e] = int'(rnd() % 256);
        1: sm[e] = int'(rnd() % 4);
        2: sm[e] = 77;
        default: sm[e] = 0;
      endcase
  endfunction

  function automatic void route();
    int ns[NN];
    bit tk[NE];
    bit ntk[NN];
    int best;
    for (int e = 0; e < NE; e++) begin key[e] = sm[e] + bm[e]; tk[e] = 0; end
    for (int n = 0; n < NN; n++) begin
      ns[n] = 0;
      for (int j = 0; j < KPN; j++) begin
        best = -1;
        for (int a = 0; a < EPN; a++) begin
          int e;
          e = n * EPN + a;
          if (!tk[e] && (best < 0 || key[e] > key[best])) best = e;
        end
        tk[best] = 1;
        ns[n] += key[best];
      end
    end
    for (int n = 0; n < NN; n++) begin ntk[n] = 0; nok[n] = 0; end
    for (int j = 0; j < MM; j++) begin
      best = -1;
      for (int n = 0; n < NN; n++)
        if (!ntk[n] && (best < 0 || ns[n] > ns[best])) best = n;
      ntk[best] = 1;
      nok[best] = 1;
    end
    for (int e = 0; e < NE; e++) tk[e] = 0;
    for (int r = 0; r < KK; r++) begin
      best = -1;
      for (int e = 0; e < NE; e++)
        if (nok[e/EPN] && !tk[e] && (best < 0 || key[e] > key[best])) best = e;
      tk[best] = 1;
      sel[r] = best;
    end
  endfunction

  function automatic void model_step();
    for (int e = 0; e < NE; e++) begin
      if (cm[e] * NE > tm * KK) bm[e] = (bm[e] - GAM < -128) ? -128 : bm[e] - GAM;
      else if (cm[e] * NE < tm * KK) bm[e] = (bm[e] + GAM > 127) ? 127 : bm[e] + GAM;
      cm[e] = 0;
    end
    tm = 0;
  endfunction

  task automatic check_bias(input string req);
    for (int e = 0; e < NE; e++) begin
      int act;
      act = int'($signed(bias_q[e*BW +: BW]));
      chk(act == bm[e], (bm[e] == 127 || bm[e] == -128) ? "R8" : req, $sformatf("bias[%0d]", e), act, bm[e]);
    end
  endtask

  task automatic run_token(input bit with_step, input bit inject);
    int sum, g, act;
    logic [KK*IW-1:0] held;
    route();
    for (int e = 0; e < NE; e++) in_score[e*SW +: SW] = sm[e][SW-1:0];
    in_valid = 1'b1;
    step_end = with_step;
    @(posedge clk);
    #1 in_valid = 1'b0;
    step_end = 1'b0;
    if (with_step) model_step();
    for (int r = 0; r < KK; r++) cm[sel[r]]++;
    tm++;
    for (int c = 1; c < LAT; c++) begin
      if (inject && c == 5) begin in_score = ~in_score; in_valid = 1'b1; end
      @(posedge clk);
      #1 in_valid = 1'b0;
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R4", "strobe one cycle early", out_valid, 0);
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b1, "R4", "strobe at latency", out_valid, 1);
    chk(busy == 1'b0, "R5", "busy at strobe", busy, 0);
    sum = 0;
    for (int r = 0; r < KK; r++) sum += sm[sel[r]];
    for (int r = 0; r < KK; r++) begin
      act = int'(out_idx[r*IW +: IW]);
      chk(act == sel[r], "R1 R2", $sformatf("index slot %0d", r), act, sel[r]);
      g = (sum == 0) ? 0 : (sm[sel[r]] * (1 << FR)) / sum;
      act = int'(out_gate[r*GW +: GW]);
      chk(act == g, "R3", $sformatf("gate slot %0d", r), act, g);
    end
    held = out_idx;
    @(negedge clk);
    chk(out_valid == 1'b0 && out_idx == held, "R4", "strobe drop and hold", out_valid, 0);
    check_bias(with_step ? "R7" : "R10");
    if (inject) begin
      int extra;
      extra = 0;
      for (int c = 0; c < LAT + 4; c++) begin @(negedge clk); if (out_valid) extra++; end
      chk(extra == 0, "R5", "result from token offered while busy", extra, 0);
    end
  endtask

  task automatic do_step(input string req);
    step_end = 1'b1;
    @(posedge clk);
    #1 step_end = 1'b0;
    model_step();
    @(negedge clk);
    check_bias(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog expired actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; step_end = 1'b0; in_score = '0; tm = 0;
    for (int e = 0; e < NE; e++) begin bm[e] = 0; cm[e] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && out_valid == 0, "R9", "control after reset", {busy, out_valid}, 0);
    chk(out_idx == '0 && out_gate == '0, "R9", "outputs after reset", out_gate, 0);
    check_bias("R9");

    // R7: three disjoint tokens give every expert the mean load, so no bias moves
    for (int t = 0; t < 3; t++) begin
      for (int e = 0; e < NE; e++) sm[e] = (e / 4 == t) ? 200 : 10;
      run_token(1'b0, 1'b0);
    end
    do_step("R7");

    // R1 R2 R3 R5 R6: mixed patterns, with one token offered inside the busy window
    for (int t = 0; t < 40; t++) begin
      set_pattern(t % 4);
      run_token(1'b0, t == 7);
    end
    do_step("R6 R7");

    // R8: one group kept overloaded until both limits are reached
    for (int s = 0; s < 5; s++) begin
      for (int t = 0; t < 3; t++) begin
        for (int e = 0; e < NE; e++) sm[e] = (e < 4) ? 255 : 0;
        run_token(1'b0, 1'b0);
      end
      do_step("R7");
    end

    // R7: a token accepted together with the step pulse counts toward the new step
    set_pattern(0);
    run_token(1'b1, 1'b0);
    for (int t = 0; t < 6; t++) begin set_pattern(t % 2); run_token(1'b0, 1'b0); end
    do_step("R6 R7");

    for (int t = 0; t < 24; t++) begin
      set_pattern(t % 4);
      run_token(1'b0, 1'b0);
    end
    do_step("R6 R7");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule